// File: doc/BRIEF.md
# Command Register Interface with Deferred Readback

This block sits behind an already deserialized control channel. Each command arrives as two bytes in one cycle. The first byte carries a 7-bit register address and an operation flag, and the second byte carries data. A write command updates a configuration register at once. A readback command returns nothing in its own cycle. It marks a readback as pending and raises the interrupt line, and the register contents are returned on a later service cycle. Any command cycle counts as a service cycle, whether it is a no-operation or a new command.

Other parts of the device report their events as 16-bit words. These words are held in an ordered interrupt stack. A pending readback always sits below every event in that stack, including events that arrive after the readback was requested. Each command cycle pops exactly one item and reports it on the response port. When nothing is pending, the response is the no-change word 0x0000. The register contents drive configuration outputs to the rest of the device.

Top module: `cmdreg_if`

## Requirements
- R1: After a synchronous active-low reset, all configuration outputs are 0x00, `irq` is low and `resp_valid` is low. `resp_valid` is high exactly in the cycle after each cycle in which `cmd_valid` was high.
- R2: A command with `cmd_hi[0]`=0 writes `cmd_lo` into the register addressed by `cmd_hi[7:1]`. The new value is visible on that register's output after the clock edge. Addresses: 0x01 CR1 (`cfg_cr1`), 0x02 CR2 (`cfg_cr2`), 0x03 CR3 (`cfg_cr3`), 0x04 OPR (`cfg_opr`), and 0x10+i for slot register i, where slot i is `cfg_tsa[8i+7:8i]`.
- R3: Bit 0 of CR2 always reads 0, whatever data is written to CR2.
- R4: A write to an address outside the map leaves every register unchanged.
- R5: A readback command (`cmd_hi[0]`=1, known address) does not return the register in its own response. From the next cycle on, `irq` is high.
- R6: The service cycle that delivers a readback responds with {address, 1'b1, current register contents}. The contents are read at delivery time.
- R7: A command cycle with nothing pending responds with 0x0000.
- R8: Event words are returned in arrival order, one for each command cycle. `irq` is high while any event or readback is pending.
- R9: A pending readback is delivered only when no events remain, including events that arrived after the readback was requested.
- R10: A second readback request replaces the pending one. A write command does not cancel a pending readback.
- R11: The stack holds EV_DEPTH (default 4) events. An event that arrives when the stack is full, with no pop in the same cycle, is dropped.
- R12: A readback command to an address outside the map is ignored. It does not set a pending readback and does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_hi | input | 8 | First byte: address [7:1], read flag [0] |
| cmd_lo | input | 8 | Second byte: write data |
| ev_valid | input | 1 | Event word present this cycle |
| ev_word | input | 16 | Event word to queue |
| resp_valid | output | 1 | Response word valid |
| resp_word | output | 16 | Event word, readback word or 0x0000 |
| irq | output | 1 | Something is pending |
| cfg_cr1 | output | 8 | CR1 contents |
| cfg_cr2 | output | 8 | CR2 contents |
| cfg_cr3 | output | 8 | CR3 contents |
| cfg_opr | output | 8 | OPR contents |
| cfg_tsa | output | 8*N_TSA | Slot registers, slot i at [8i+7:8i] |

## Verification
The hardest situation to reach is a readback that stays pending while events keep arriving and being popped. This must happen both when a write to the same register lands before delivery and when a new readback overwrites the old one. Directed sequences set up each of these orderings on purpose, including the case where the stack overflows. A long random run then mixes commands, addresses outside the map and events at a rate high enough that the stack often fills while a readback waits.

// File: rtl/cmdreg_pkg.sv
// Package: shared address map, field layout and the address-validity helper
// for the command register interface.
package cmdreg_pkg;
    localparam logic [6:0]  A_CR1     = 7'h01;
    localparam logic [6:0]  A_CR2     = 7'h02;
    localparam logic [6:0]  A_CR3     = 7'h03;
    localparam logic [6:0]  A_OPR     = 7'h04;
    localparam logic [6:0]  A_TSA0    = 7'h10;
    localparam logic [15:0] NO_CHANGE = 16'h0000;

    // Two-byte command as it arrives on the control port.
    typedef struct packed {
        logic [6:0] addr;
        logic       rd;
        logic [7:0] data;
    } cmd_t;

    // True when the address names a register that exists.
    function automatic logic addr_known(input logic [6:0] a, input int n_tsa);
        addr_known = (a >= A_CR1 && a <= A_OPR) ||
                     (a >= A_TSA0 && int'(a) < int'(A_TSA0) + n_tsa);
    endfunction
endpackage

// File: rtl/cmdreg_file.sv
// Module: cmdreg_file
// Holds the configuration registers and drives them out to the device.
// One write port and one combinational read port.
// Assumes: wr_en is asserted only for known addresses (the top decodes this).
module cmdreg_file
    import cmdreg_pkg::*;
#(
    parameter int N_TSA = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [6:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [6:0]         rd_addr,
    output logic [7:0]         rd_data,
    output logic [7:0]         cfg_cr1,
    output logic [7:0]         cfg_cr2,
    output logic [7:0]         cfg_cr3,
    output logic [7:0]         cfg_opr,
    output logic [8*N_TSA-1:0] cfg_tsa
);
    logic [7:0] cr1_q, cr2_q, cr3_q, opr_q;
    logic [7:0] tsa_q [N_TSA];

    // Register storage: reset to zero, update on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr1_q <= '0;
            cr2_q <= '0;
            cr3_q <= '0;
            opr_q <= '0;
            for (int i = 0; i < N_TSA; i++) tsa_q[i] <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CR1) cr1_q <= wr_data;
            if (wr_addr == A_CR2) cr2_q <= {wr_data[7:1], 1'b0};
            if (wr_addr == A_CR3) cr3_q <= wr_data;
            if (wr_addr == A_OPR) opr_q <= wr_data;
            for (int i = 0; i < N_TSA; i++)
                if (wr_addr == A_TSA0 + 7'(i)) tsa_q[i] <= wr_data;
        end
    end

    // Read mux for readback delivery.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CR1) rd_data = cr1_q;
        if (rd_addr == A_CR2) rd_data = cr2_q;
        if (rd_addr == A_CR3) rd_data = cr3_q;
        if (rd_addr == A_OPR) rd_data = opr_q;
        for (int i = 0; i < N_TSA; i++)
            if (rd_addr == A_TSA0 + 7'(i)) rd_data = tsa_q[i];
    end

    assign cfg_cr1 = cr1_q;
    assign cfg_cr2 = cr2_q;
    assign cfg_cr3 = cr3_q;
    assign cfg_opr = opr_q;

    // Flatten the slot registers onto the output bus.
    for (genvar g = 0; g < N_TSA; g++) begin : g_tsa_out
        assign cfg_tsa[8*g +: 8] = tsa_q[g];
    end
endmodule

// File: rtl/cmdreg_evfifo.sv
// Module: cmdreg_evfifo
// First-in first-out store for pending event words.
// A push is accepted when there is room, or when a pop in the same cycle
// frees a slot. Otherwise the push is dropped.
// Assumes: DEPTH is a power of two; pop is asserted only when count != 0.
module cmdreg_evfifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok;

    assign push_ok = push && ((count < CNT_W'(DEPTH)) || pop);
    assign head    = mem[rd_ptr];

    // Storage write: data only, no reset needed.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop)     rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/cmdreg_if.sv
// Module: cmdreg_if (top)
// Decodes two-byte commands, writes or arms a readback of the registers,
// and answers each command cycle with one item from the interrupt stack.
// Events come first, in arrival order. A pending readback is delivered
// only after them. With nothing pending, the answer is the no-change word.
// Assumes: commands arrive already deserialized, one for each cmd_valid cycle.
module cmdreg_if
    import cmdreg_pkg::*;
#(
    parameter int N_TSA    = 4,
    parameter int EV_DEPTH = 4,
    localparam int CNT_W   = $clog2(EV_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_hi,
    input  logic [7:0]         cmd_lo,
    input  logic               ev_valid,
    input  logic [15:0]        ev_word,
    output logic               resp_valid,
    output logic [15:0]        resp_word,
    output logic               irq,
    output logic [7:0]         cfg_cr1,
    output logic [7:0]         cfg_cr2,
    output logic [7:0]         cfg_cr3,
    output logic [7:0]         cfg_opr,
    output logic [8*N_TSA-1:0] cfg_tsa
);
    cmd_t             cmd;
    logic             known;
    logic             wr_en, rb_req, pop, rb_deliver;
    logic             rb_pend_q;
    logic [6:0]       rb_addr_q;
    logic [7:0]       rd_data;
    logic [15:0]      ev_head;
    logic [CNT_W-1:0] ev_count;
    logic             ev_nonempty;

    assign cmd         = cmd_t'({cmd_hi, cmd_lo});
    assign known       = addr_known(cmd.addr, N_TSA);
    assign wr_en       = cmd_valid && !cmd.rd && known;
    assign rb_req      = cmd_valid && cmd.rd && known;
    assign ev_nonempty = (ev_count != '0);
    assign pop         = cmd_valid && ev_nonempty;
    assign rb_deliver  = cmd_valid && !ev_nonempty && rb_pend_q;
    assign irq         = ev_nonempty || rb_pend_q;

    cmdreg_file #(.N_TSA(N_TSA)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (cmd.addr),
        .wr_data (cmd.data),
        .rd_addr (rb_addr_q),
        .rd_data (rd_data),
        .cfg_cr1 (cfg_cr1),
        .cfg_cr2 (cfg_cr2),
        .cfg_cr3 (cfg_cr3),
        .cfg_opr (cfg_opr),
        .cfg_tsa (cfg_tsa)
    );

    cmdreg_evfifo #(.DEPTH(EV_DEPTH), .W(16)) u_evq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ev_valid),
        .push_data (ev_word),
        .pop       (pop),
        .head      (ev_head),
        .count     (ev_count)
    );

    // Readback slot: bottom of the stack; a new request overrides delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_pend_q <= 1'b0;
            rb_addr_q <= '0;
        end else if (rb_req) begin
            rb_pend_q <= 1'b1;
            rb_addr_q <= cmd.addr;
        end else if (rb_deliver) begin
            rb_pend_q <= 1'b0;
        end
    end

    // Response register: one word per command cycle, from pre-edge state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_word  <= NO_CHANGE;
        end else begin
            resp_valid <= cmd_valid;
            if (cmd_valid) begin
                if (pop)             resp_word <= ev_head;
                else if (rb_deliver) resp_word <= {rb_addr_q, 1'b1, rd_data};
                else                 resp_word <= NO_CHANGE;
            end
        end
    end
endmodule

// File: rtl/cmdreg_if_chk.sv
// Module: cmdreg_if_chk
// Temporal checks on the command register interface.
// Attached to every cmdreg_if instance by the bind at the end of this file.
module cmdreg_if_chk
    import cmdreg_pkg::*;
#(
    parameter int N_TSA    = 4,
    parameter int EV_DEPTH = 4,
    localparam int CNT_W   = $clog2(EV_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [7:0]       cmd_hi,
    input logic             irq,
    input logic             resp_valid,
    input logic [15:0]      resp_word,
    input logic [7:0]       cfg_cr2,
    input logic [CNT_W-1:0] ev_count,
    input logic             rb_pend_q
);
    // R1: one response for each command, none otherwise
    a_r1_resp_tracks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> resp_valid);
    a_r1_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !resp_valid);
    // R7: idle service gives the no-change word
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !irq) |=> (resp_word == NO_CHANGE));
    // R3: CR2 bit 0 stays clear
    a_r3_cr2_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cr2[0] == 1'b0);
    // R5: a valid readback request raises the interrupt
    a_r5_rb_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_hi[0] && addr_known(cmd_hi[7:1], N_TSA)) |=> irq);
    // R9: readback survives while events are served ahead of it
    a_r9_rb_behind_events: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ev_count != '0 && rb_pend_q) |=> rb_pend_q);
    // R11: occupancy never exceeds the stack depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ev_count <= CNT_W'(EV_DEPTH));
endmodule

bind cmdreg_if cmdreg_if_chk #(.N_TSA(N_TSA), .EV_DEPTH(EV_DEPTH)) u_chk (.*);

// File: tb/cmdreg_if_bench.sv
// Bench for cmdreg_if: directed corner cases, then seeded random traffic,
// each cycle compared against a behavioural model held in the bench.
module cmdreg_if_bench;
    localparam int CLK_P    = 10;
    localparam int N_TSA    = 4;
    localparam int EV_DEPTH = 4;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cmd_valid;
    logic [7:0]         cmd_hi, cmd_lo;
    logic               ev_valid;
    logic [15:0]        ev_word;
    logic               resp_valid;
    logic [15:0]        resp_word;
    logic               irq;
    logic [7:0]         cfg_cr1, cfg_cr2, cfg_cr3, cfg_opr;
    logic [8*N_TSA-1:0] cfg_tsa;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // model state
    logic [7:0]  mreg [128];
    logic [15:0] mq [$];
    bit          m_rbp;
    logic [6:0]  m_rba;

    always #(CLK_P/2) clk = ~clk;

    cmdreg_if #(.N_TSA(N_TSA), .EV_DEPTH(EV_DEPTH)) u_cmdreg_if (.*);

    function automatic bit ok_addr(input logic [6:0] a);
        return (a >= 7'h01 && a <= 7'h04) || (a >= 7'h10 && a < 7'h10 + 7'(N_TSA));
    endfunction

    function automatic logic [8*N_TSA-1:0] exp_tsa();
        logic [8*N_TSA-1:0] v;
        for (int i = 0; i < N_TSA; i++) v[8*i +: 8] = mreg[16 + i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive, advance the model, check after the edge.
    task automatic step(input bit cv, input logic [7:0] hi, input logic [7:0] lo,
                        input bit ev, input logic [15:0] ew, input string tag);
        logic [15:0] exp_rw;
        logic [6:0]  a;
        @(negedge clk);
        cmd_valid = cv; cmd_hi = hi; cmd_lo = lo; ev_valid = ev; ev_word = ew;
        a = hi[7:1];
        exp_rw = 16'h0000;
        if (cv) begin
            if (mq.size() > 0) exp_rw = mq.pop_front();
            else if (m_rbp) begin exp_rw = {m_rba, 1'b1, mreg[m_rba]}; m_rbp = 0; end
        end
        if (cv && !hi[0] && ok_addr(a)) begin
            mreg[a] = lo;
            if (a == 7'h02) mreg[2][0] = 1'b0;
        end
        if (cv && hi[0] && ok_addr(a)) begin m_rbp = 1; m_rba = a; end
        if (ev && mq.size() < EV_DEPTH) mq.push_back(ew);
        @(posedge clk);
        #1;
        cmd_valid = 0; ev_valid = 0;
        chk(resp_valid == cv, "R1 resp_valid", 64'(resp_valid), 64'(cv));
        if (cv) chk(resp_word == exp_rw, tag, 64'(resp_word), 64'(exp_rw));
        chk(irq == (mq.size() > 0 || m_rbp), "R8 irq", 64'(irq), 64'(mq.size() > 0 || m_rbp));
        chk({cfg_cr1, cfg_cr2, cfg_cr3, cfg_opr} == {mreg[1], mreg[2], mreg[3], mreg[4]},
            "R2 cfg", 64'({cfg_cr1, cfg_cr2, cfg_cr3, cfg_opr}),
            64'({mreg[1], mreg[2], mreg[3], mreg[4]}));
        chk(cfg_tsa == exp_tsa(), "R2 tsa", 64'(cfg_tsa), 64'(exp_tsa()));
    endtask

    task automatic cmd(input logic [6:0] a, input bit rd, input logic [7:0] d, input string tag);
        step(1, {a, rd}, d, 0, 16'h0, tag);
    endtask

    task automatic evt(input logic [15:0] w);
        step(0, 8'h00, 8'h00, 1, w, "R8 event");
    endtask

    // Watchdog: a hang counts as one failed check.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [6:0] pick [13] = '{7'h01, 7'h02, 7'h03, 7'h04, 7'h10, 7'h11, 7'h12,
                                  7'h13, 7'h00, 7'h05, 7'h0F, 7'h14, 7'h7F};
        void'($urandom(32'd2024));
        for (int i = 0; i < 128; i++) mreg[i] = 8'h00;
        m_rbp = 0; m_rba = '0;
        cmd_valid = 0; cmd_hi = 0; cmd_lo = 0; ev_valid = 0; ev_word = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(irq == 0 && resp_valid == 0, "R1 reset irq/resp", 64'({irq, resp_valid}), 64'(0));
        chk({cfg_cr1, cfg_cr2, cfg_cr3, cfg_opr, cfg_tsa} == '0, "R1 reset cfg",
            64'({cfg_cr1, cfg_cr2, cfg_cr3, cfg_opr}), 64'(0));

        cmd(7'h00, 0, 8'h00, "R7 idle no-change");
        cmd(7'h01, 0, 8'hA5, "R2 write CR1");
        cmd(7'h02, 0, 8'hFF, "R3 CR2 lsb clear");
        cmd(7'h13, 0, 8'h3C, "R2 write slot 3");
        cmd(7'h05, 0, 8'h77, "R4 unmapped write");
        cmd(7'h7F, 0, 8'h99, "R4 unmapped write");
        // R5/R6 readback in own cycle then on a NOP
        cmd(7'h02, 1, 8'h00, "R5 no data in own cycle");
        cmd(7'h00, 0, 8'h00, "R6 readback word");
        cmd(7'h00, 0, 8'h00, "R7 idle after delivery");
        // R9 readback waits behind events that arrive later
        cmd(7'h01, 1, 8'h00, "R5 readback CR1");
        evt(16'h1234);
        evt(16'hBEEF);
        cmd(7'h00, 0, 8'h00, "R8 first event");
        evt(16'h4242);
        cmd(7'h00, 0, 8'h00, "R8 second event");
        cmd(7'h00, 0, 8'h00, "R9 third event before readback");
        cmd(7'h00, 0, 8'h00, "R9 readback last");
        // R10 replacement and write not cancelling
        cmd(7'h01, 1, 8'h00, "R10 first request");
        cmd(7'h04, 1, 8'h00, "R10 second request replaces");
        cmd(7'h00, 0, 8'h00, "R10 only newest delivered");
        cmd(7'h00, 0, 8'h00, "R10 nothing after");
        cmd(7'h03, 1, 8'h00, "R10 request CR3");
        cmd(7'h03, 0, 8'h11, "R10 write keeps readback");
        cmd(7'h00, 0, 8'h00, "R6 current contents");
        // R11 overflow drop
        for (int i = 0; i < 5; i++) evt(16'hE000 + 16'(i));
        for (int i = 0; i < 5; i++) cmd(7'h00, 0, 8'h00, "R11 overflow drop");
        // R12 unmapped readback ignored
        cmd(7'h05, 1, 8'h00, "R12 unmapped readback");
        cmd(7'h00, 0, 8'h00, "R12 nothing pending");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [6:0] a;
            a = pick[$urandom % 13];
            step(($urandom % 3) != 0, {a, 1'($urandom)}, 8'($urandom),
                 ($urandom % 3) == 0, 16'($urandom), "R9 random response");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule